// File: doc/BRIEF.md
# Row-Broadcast Partial-Sum Block Matcher

This block is an intra-level full-search matching engine for one NxN current block. It holds the current block in N row arrays, each owning one row of current pixels. Each cycle, every row array receives a row of N adjacent reference pixels, forms N absolute differences, and reduces them to a row sum. The row sums join a running partial sum that steps down a chain of N registers. The register at the bottom of the chain therefore delivers a complete block SAD for one candidate displacement every cycle.

The search covers horizontal and vertical displacements from -P to +P. Candidates come out column by column (dx rising), and top to bottom inside each column (dy rising). Reference data arrives on two row-wide ports. Columns with an even index use one port and columns with an odd index use the other. The next column can therefore start while the last rows of the previous column are still in the chain, and the output stream has no gaps. A motion search controller loads the current block, pulses `start`, and streams reference rows on a fixed schedule. It then takes one `(dx, dy, SAD)` triple per cycle and uses it for its own minimum search.

Top module: `sad_rowcast_engine`

## Requirements
- R1: After reset, and until a search is started, `out_valid` is low.
- R2: Call the edge that samples `start` high while idle S. The first result, at displacement (dx, dy) = (-P, -P), is on the outputs after edge S+N. Result number n (counting from 0) is on the outputs after edge S+N+n.
- R3: A search delivers exactly (2P+1)^2 results on consecutive cycles with `out_valid` high, and `out_valid` is low in the cycle after the last result.
- R4: Results come out in this order: dx from -P to +P, and for each dx, dy from -P to +P. `out_dx` and `out_dy` are two's complement.
- R5: `out_sad` is the sum over i, j of |cur(i,j) - ref(i+dy+P, j+dx+P)|. Current pixel (row i, column j) is `cur_blk[(i*N+j)*8 +: 8]`. Window pixels are indexed from the top-left of the (2P+N)-square search window. Pixels are unsigned 8-bit.
- R6: Column c = dx+P is fed on `ref_even` when c is even and on `ref_odd` when c is odd. Window row j (j = 0 to 2P+N-1), pixels c to c+N-1, must be on that port, with pixel x at bits [x*8 +: 8], at edge S+1+c*(2P+1)+j. The other port is ignored at that edge unless it carries a row of its own column.
- R7: A `start` pulse sampled at edges S+1 through S+(2P+1)^2 is ignored: the result stream of the running search is neither restarted nor lengthened.
- R8: `cur_load` high at an edge captures `cur_blk` into the row arrays. The block is held unchanged until the next load.
- R9: An exact match gives SAD 0, and the largest possible mismatch gives N*N*255 without wrap-around. The output width is 8+2*log2(N) bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_load | input | 1 | Capture the current block this edge |
| cur_blk | input | N*N*8 | Current block, row-major, 8 bits per pixel |
| start | input | 1 | Begin a search (sampled while idle) |
| ref_even | input | N*8 | Reference row for even column indices |
| ref_odd | input | N*8 | Reference row for odd column indices |
| out_valid | output | 1 | A candidate result is present |
| out_sad | output | 8+2*log2(N) | Block SAD of the present candidate |
| out_dx | output | log2c(2P+1)+1 | Horizontal displacement, signed |
| out_dy | output | log2c(2P+1)+1 | Vertical displacement, signed |

## Verification
A stage taking its row from the wrong port corrupts the first N-1 results of every column after column 0. This shows up as a SAD mismatch within N cycles of each column boundary. A fault in a row array's sum or in its stored current row shifts every SAD of the search, starting with the first result N cycles after start. A sequencer or tag-pipeline fault appears at once as a break in the (dx, dy) order, a changed result count, or a first result in the wrong cycle. The bench compares each result against a window model in the cycle it is due, so any of these faults is caught within one result of its first effect.

// File: rtl/sadrb_pkg.sv
package sadrb_pkg;

  // Pixel format is fixed: unsigned 8-bit samples.
  localparam int PIX_W = 8;

  typedef logic [PIX_W-1:0] pix_t;

  // Absolute difference of two pixels.
  function automatic pix_t abs_diff(pix_t a, pix_t b);
    return (a >= b) ? pix_t'(a - b) : pix_t'(b - a);
  endfunction

  // Width needed to hold the sum of cnt pixel differences.
  function automatic int sum_width(int cnt);
    return PIX_W + $clog2(cnt);
  endfunction

  // Signed displacement from a 0-based scan index and the range radius.
  function automatic int idx_to_disp(int idx, int radius);
    return idx - radius;
  endfunction

endpackage

// File: rtl/sadrb_row_array.sv
module sadrb_row_array
  import sadrb_pkg::*;
#(
  parameter int N = 4,
  localparam int ROW_W = N * PIX_W,
  localparam int RS_W = PIX_W + $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] cur_row_in,
  input  logic [ROW_W-1:0] ref_row,
  output logic [RS_W-1:0]  row_sad
);

  // Current pixels held in the processing elements.
  pix_t cur_q [N];

  for (genvar j = 0; j < N; j++) begin : g_pe
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        cur_q[j] <= '0;
      else if (load)
        cur_q[j] <= cur_row_in[j*PIX_W +: PIX_W];
    end
  end

  // One-dimensional reduction of the N differences.
  always_comb begin
    row_sad = '0;
    for (int j = 0; j < N; j++)
      row_sad = row_sad + RS_W'(abs_diff(cur_q[j], ref_row[j*PIX_W +: PIX_W]));
  end

endmodule

// File: rtl/sadrb_psum_stage.sv
module sadrb_psum_stage
  import sadrb_pkg::*;
#(
  parameter int N = 4,
  localparam int ROW_W = N * PIX_W,
  localparam int RS_W = PIX_W + $clog2(N),
  localparam int SAD_W = PIX_W + 2 * $clog2(N)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [ROW_W-1:0] cur_row_in,
  input  logic [ROW_W-1:0] ref_even,
  input  logic [ROW_W-1:0] ref_odd,
  input  logic             use_odd,
  input  logic [SAD_W-1:0] psum_in,
  output logic [SAD_W-1:0] psum_out
);

  logic [ROW_W-1:0] ref_pick;
  logic [RS_W-1:0]  row_sad;

  // Each stage picks the port of the column its candidate belongs to.
  assign ref_pick = use_odd ? ref_odd : ref_even;

  sadrb_row_array #(.N(N)) row_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (load),
    .cur_row_in(cur_row_in),
    .ref_row   (ref_pick),
    .row_sad   (row_sad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      psum_out <= '0;
    else
      psum_out <= psum_in + SAD_W'(row_sad);
  end

endmodule

// File: rtl/sadrb_scan_seq.sv
module sadrb_scan_seq #(
  parameter int P = 2,
  localparam int SPAN = 2 * P + 1,
  localparam int CIW = (SPAN > 1) ? $clog2(SPAN) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  output logic           active,
  output logic [CIW-1:0] col,
  output logic [CIW-1:0] row
);

  localparam logic [CIW-1:0] IDX_LAST = CIW'(SPAN - 1);

  logic at_last;
  assign at_last = (col == IDX_LAST) && (row == IDX_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active <= 1'b0;
      col    <= '0;
      row    <= '0;
    end else if (!active) begin
      if (start) begin
        active <= 1'b1;
        col    <= '0;
        row    <= '0;
      end
    end else if (at_last) begin
      active <= 1'b0;
      col    <= '0;
      row    <= '0;
    end else if (row == IDX_LAST) begin
      row <= '0;
      col <= col + 1'b1;
    end else begin
      row <= row + 1'b1;
    end
  end

endmodule

// File: rtl/sad_rowcast_engine.sv
module sad_rowcast_engine
  import sadrb_pkg::*;
#(
  parameter int N = 4,
  parameter int P = 2,
  localparam int SPAN = 2 * P + 1,
  localparam int CIW = (SPAN > 1) ? $clog2(SPAN) : 1,
  localparam int CW = CIW + 1,
  localparam int ROW_W = N * PIX_W,
  localparam int BLK_W = N * ROW_W,
  localparam int SAD_W = PIX_W + 2 * $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cur_load,
  input  logic [BLK_W-1:0]     cur_blk,
  input  logic                 start,
  input  logic [ROW_W-1:0]     ref_even,
  input  logic [ROW_W-1:0]     ref_odd,
  output logic                 out_valid,
  output logic [SAD_W-1:0]     out_sad,
  output logic signed [CW-1:0] out_dx,
  output logic signed [CW-1:0] out_dy
);

  // Scan sequencer state, visible to the checker.
  logic           seq_active;
  logic [CIW-1:0] seq_col;
  logic [CIW-1:0] seq_row;

  sadrb_scan_seq #(.P(P)) seq_i (
    .clk   (clk),
    .rst_n (rst_n),
    .start (start),
    .active(seq_active),
    .col   (seq_col),
    .row   (seq_row)
  );

  // Candidate tags, delayed one cycle per stage of the chain.
  logic                 tag_act [N];
  logic                 tag_odd [N];
  logic signed [CW-1:0] tag_dx  [N];
  logic signed [CW-1:0] tag_dy  [N];

  assign tag_act[0] = seq_active;
  assign tag_odd[0] = seq_col[0];
  assign tag_dx[0]  = CW'(idx_to_disp(int'(seq_col), P));
  assign tag_dy[0]  = CW'(idx_to_disp(int'(seq_row), P));

  for (genvar i = 1; i < N; i++) begin : g_tag
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        tag_act[i] <= 1'b0;
        tag_odd[i] <= 1'b0;
        tag_dx[i]  <= '0;
        tag_dy[i]  <= '0;
      end else begin
        tag_act[i] <= tag_act[i-1];
        tag_odd[i] <= tag_odd[i-1];
        tag_dx[i]  <= tag_dx[i-1];
        tag_dy[i]  <= tag_dy[i-1];
      end
    end
  end

  // Vertical chain of partial sums.
  logic [SAD_W-1:0] psum [N+1];
  assign psum[0] = '0;

  for (genvar i = 0; i < N; i++) begin : g_stage
    sadrb_psum_stage #(.N(N)) stage_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (cur_load),
      .cur_row_in(cur_blk[i*ROW_W +: ROW_W]),
      .ref_even  (ref_even),
      .ref_odd   (ref_odd),
      .use_odd   (tag_odd[i]),
      .psum_in   (psum[i]),
      .psum_out  (psum[i+1])
    );
  end

  assign out_sad = psum[N];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_dx    <= '0;
      out_dy    <= '0;
    end else begin
      out_valid <= tag_act[N-1];
      out_dx    <= tag_dx[N-1];
      out_dy    <= tag_dy[N-1];
    end
  end

endmodule

// File: rtl/sadrb_chk.sv
module sadrb_chk #(
  parameter int N = 4,
  parameter int P = 2,
  localparam int SPAN = 2 * P + 1,
  localparam int CIW = (SPAN > 1) ? $clog2(SPAN) : 1,
  localparam int CW = CIW + 1,
  localparam int SAD_W = 8 + 2 * $clog2(N),
  localparam int TOTAL = SPAN * SPAN,
  localparam int MAX_SAD = N * N * 255
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 start,
  input logic                 out_valid,
  input logic [SAD_W-1:0]     out_sad,
  input logic signed [CW-1:0] out_dx,
  input logic signed [CW-1:0] out_dy,
  input logic                 seq_active,
  input logic [CIW-1:0]       seq_col,
  input logic [CIW-1:0]       seq_row
);

  localparam logic signed [CW-1:0] LO = CW'(-P);
  localparam logic signed [CW-1:0] HI = CW'(P);

  // Results seen in the present run, wrapping at TOTAL.
  logic        prev_valid;
  logic [31:0] vcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_valid <= 1'b0;
      vcnt       <= '0;
    end else begin
      prev_valid <= out_valid;
      if (out_valid)
        vcnt <= (!prev_valid || vcnt == 32'(TOTAL)) ? 32'd1 : vcnt + 32'd1;
    end
  end

  // R2: the stream opens at the top of the leftmost column.
  a_r2_first_corner: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !prev_valid) |-> (out_dx == LO && out_dy == LO));

  // R3: a run holds exactly TOTAL consecutive results.
  a_r3_run_length: assert property (@(posedge clk) disable iff (!rst_n)
    (prev_valid && !out_valid) |-> (vcnt == 32'(TOTAL)));

  // R4: inside a column dy steps by one, dx held.
  a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && prev_valid && $past(out_dy) != HI) |->
      (out_dy == $past(out_dy) + 1'b1 && out_dx == $past(out_dx)));

  // R4: column turn goes to the top of the next column.
  a_r4_column_turn: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && prev_valid && $past(out_dy) == HI && $past(out_dx) != HI) |->
      (out_dy == LO && out_dx == $past(out_dx) + 1'b1));

  // R4: coordinates stay inside the search range.
  a_r4_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_dx >= LO && out_dx <= HI && out_dy >= LO && out_dy <= HI));

  // R7: a start pulse during the issue phase does not rewind the scan.
  a_r7_no_restart: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_active && start && !(seq_col == CIW'(SPAN-1) && seq_row == CIW'(SPAN-1))) |=>
      (seq_active && (seq_col != '0 || seq_row != '0)));

  // R9: the block SAD never exceeds the largest possible mismatch.
  a_r9_sad_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (int'(out_sad) <= MAX_SAD));

endmodule

bind sad_rowcast_engine sadrb_chk #(.N(N), .P(P)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start),
  .out_valid (out_valid),
  .out_sad   (out_sad),
  .out_dx    (out_dx),
  .out_dy    (out_dy),
  .seq_active(seq_active),
  .seq_col   (seq_col),
  .seq_row   (seq_row)
);

// File: tb/sad_rowcast_engine_tb.sv
module sad_rowcast_engine_tb_top;

  localparam int N = 4;
  localparam int P = 2;
  localparam int SPAN = 2 * P + 1;
  localparam int WIN = 2 * P + N;
  localparam int TOTAL = SPAN * SPAN;
  localparam int CW = $clog2(SPAN) + 1;
  localparam int SAD_W = 8 + 2 * $clog2(N);

  // Vector table: cur seed, window seed, mode, match dx index, match dy index, poke start.
  // mode 0: independent patterns, 1: block copied from window, 2: all-255 vs all-0.
  localparam int NV = 5;
  localparam int VEC [NV][6] = '{
    '{ 3, 11, 0, 0, 0, 0},
    '{ 7, 19, 1, 3, 1, 1},
    '{ 0,  0, 2, 0, 0, 0},
    '{ 5, 42, 1, 0, 4, 0},
    '{91, 23, 0, 0, 0, 1}
  };

  logic                 clk = 1'b0;
  logic                 rst_n = 1'b0;
  logic                 cur_load = 1'b0;
  logic [N*N*8-1:0]     cur_blk = '0;
  logic                 start = 1'b0;
  logic [N*8-1:0]       ref_even = '0;
  logic [N*8-1:0]       ref_odd = '0;
  logic                 out_valid;
  logic [SAD_W-1:0]     out_sad;
  logic signed [CW-1:0] out_dx;
  logic signed [CW-1:0] out_dy;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  int cur [N][N];
  int win [WIN][WIN];

  always #2 clk = ~clk;

  sad_rowcast_engine #(.N(N), .P(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .cur_load(cur_load), .cur_blk(cur_blk),
    .start(start), .ref_even(ref_even), .ref_odd(ref_odd),
    .out_valid(out_valid), .out_sad(out_sad), .out_dx(out_dx), .out_dy(out_dy)
  );

  task automatic check(bit ok, string req, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int hashpix(int s, int r, int x);
    return (s * 29 + r * 53 + x * 97 + r * x * 11 + (s >> 1)) & 255;
  endfunction

  // Model of R5: block SAD for column index c, row index k.
  function automatic int model_sad(int c, int k);
    int acc = 0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) begin
        int d = cur[i][j] - win[k+i][c+j];
        acc += (d < 0) ? -d : d;
      end
    return acc;
  endfunction

  task automatic build(int v);
    for (int r = 0; r < WIN; r++)
      for (int x = 0; x < WIN; x++)
        win[r][x] = (VEC[v][2] == 2) ? 0 : hashpix(VEC[v][1], r, x);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        case (VEC[v][2])
          1: cur[i][j] = win[VEC[v][4]+i][VEC[v][3]+j];
          2: cur[i][j] = 255;
          default: cur[i][j] = hashpix(VEC[v][0] + 200, i, j);
        endcase
  endtask

  // R6 feed schedule for the edge S+m.
  task automatic drive_ports(int m);
    ref_even = {N{8'hA5}};
    ref_odd  = {N{8'h5A}};
    for (int c = 0; c < SPAN; c++) begin
      int j = m - 1 - c * SPAN;
      if (j >= 0 && j < WIN) begin
        logic [N*8-1:0] row;
        for (int x = 0; x < N; x++) row[x*8 +: 8] = 8'(win[j][c+x]);
        if (c % 2 == 0) ref_even = row; else ref_odd = row;
      end
    end
  endtask

  task automatic run_vector(int v);
    build(v);
    @(negedge clk);
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++) cur_blk[(i*N+j)*8 +: 8] = 8'(cur[i][j]);
    cur_load = 1'b1;
    @(negedge clk);
    cur_load = 1'b0;
    cur_blk = '1; // R8: block must stay as captured
    start = 1'b1;
    drive_ports(0);
    @(posedge clk);
    for (int m = 1; m <= N + TOTAL + 3; m++) begin
      int n;
      @(negedge clk);
      n = m - 1 - N;
      if (n >= 0 && n < TOTAL) begin
        int c = n / SPAN;
        int k = n % SPAN;
        check(out_valid == 1'b1, "R2/R3 valid", int'(out_valid), 1);
        check(int'(out_dx) == c - P && int'(out_dy) == k - P, "R4 order",
              int'(out_dx) * 100 + int'(out_dy), (c - P) * 100 + (k - P));
        check(int'(out_sad) == model_sad(c, k), "R5/R6/R8 sad", int'(out_sad), model_sad(c, k));
        if (VEC[v][2] == 1 && c == VEC[v][3] && k == VEC[v][4])
          check(out_sad == '0, "R9 exact match", int'(out_sad), 0);
        if (VEC[v][2] == 2)
          check(int'(out_sad) == N * N * 255, "R9 max sad", int'(out_sad), N * N * 255);
      end else begin
        check(out_valid == 1'b0, "R3/R7 gap", int'(out_valid), 0);
      end
      start = (VEC[v][5] != 0) && (m == 10 || m == TOTAL);
      drive_ports(m);
    end
    start = 1'b0;
  endtask

  initial begin
    #20;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 reset", int'(out_valid), 0);
    rst_n = 1'b1;
    for (int t = 0; t < 6; t++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R1 idle", int'(out_valid), 0);
    end
    for (int v = 0; v < NV; v++) run_vector(v);
    // R1: no activity without a start.
    for (int t = 0; t < 8; t++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R1 idle after runs", int'(out_valid), 0);
    end
    // R1: reset in mid-run clears the output.
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (N + 3) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1 mid-run reset", int'(out_valid), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R1 stays idle", int'(out_valid), 0);
    done = 1;
  end

  initial begin
    for (int t = 0; t < 20000 && !done; t++) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule